// File: doc/BRIEF.md
# Multiline Receive Silo with Alarm

This block is the shared receive queue of an eight-line serial multiplexer. Each per-line receiver offers a finished character together with its framing-error and parity-error flags on a push port. The silo takes at most one character per clock and tags it with the number of the line that sent it. When more than one line offers a character in the same cycle, the lowest-numbered line wins. The other lines keep their requests up until they are served.

The processor side sees one 16-bit buffer word. That word shows the oldest entry, and each read strobe removes it. If a character arrives while the queue is full, that character is lost, and the next character that is stored carries an overrun flag. A receive interrupt can be raised in two ways. In immediate mode it fires whenever any entry is waiting. In alarm mode it waits until the fill level reaches a threshold, so that a busy link raises fewer interrupts. The control bits are a master scan enable, a receive interrupt enable and an alarm enable. Dropping the scan enable empties the queue and stops intake.

Top module: `mux_rx_silo`

## Requirements
- R1: The silo holds up to 64 entries. Reads return them oldest first, and each cycle with `rd_pop` high and the silo non-empty removes exactly one entry.
- R2: A valid read word has the character in bits 7:0, the source line number in bits 10:8, bit 11 at 0, the parity-error flag in bit 12, the framing-error flag in bit 13, the overrun flag in bit 14 and the valid flag (1) in bit 15. A break (character 0 with the framing flag set) passes through unchanged.
- R3: While the silo is empty, `rd_word` is all zeros, so the valid flag is clear. A read strobe on an empty silo changes nothing.
- R4: With `alarm_en` low and `rx_int_en` high, `rx_irq` is high exactly when at least one entry is stored.
- R5: With `alarm_en` high and `rx_int_en` high, `rx_irq` is high exactly when at least 16 entries are stored.
- R6: With `rx_int_en` low, `rx_irq` stays low whatever the fill level.
- R7: While scanning, the lowest-numbered line that requests receives `line_accept` in the same cycle. No other line is accepted in that cycle, and the accepted character becomes visible in `rd_word` after the next rising edge once it reaches the head.
- R8: An accepted character that meets a full silo, with no pop in the same cycle, is discarded. The next character that is stored carries the overrun flag (bit 14), and only that one does. When a pop occurs in the same cycle as a push into a full silo, the character is stored.
- R9: While `scan_en` is low, no line is accepted. After the next edge the silo is empty and any pending overrun mark is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Master scan enable; low flushes and blocks intake |
| rx_int_en | input | 1 | Receive interrupt enable |
| alarm_en | input | 1 | Selects threshold (alarm) interrupt mode |
| line_push | input | NUM_LINES | Per-line character offer, held until accepted |
| line_char | input | NUM_LINES*8 | Per-line character, line i in bits 8i+7:8i |
| line_ferr | input | NUM_LINES | Per-line framing-error flag |
| line_perr | input | NUM_LINES | Per-line parity-error flag |
| line_accept | output | NUM_LINES | One-hot acceptance of a line's offer this cycle |
| rd_pop | input | 1 | Processor read strobe; removes the head entry |
| rd_word | output | 16 | Buffer word showing the head entry |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
`line_accept` is combinational, so it is due in the same cycle as the offer. `rd_word` and `rx_irq` follow the stored state, so they change one rising edge after a push, pop or flush. `rx_irq` also follows `rx_int_en` and `alarm_en` at once. The bench drives every input just after a falling edge and samples all outputs 2 ns later. At that point it compares them with a queue model that holds the state from before the coming rising edge. The model then applies that edge's push, pop, drop or flush. This keeps every comparison exactly one register stage behind the stimulus that caused it.

// File: rtl/silo_pkg.sv
package silo_pkg;
   localparam int WORD_W    = 16;
   localparam int CHAR_W    = 8;
   localparam int LINE_W    = 3;
   localparam int LINE_LSB  = 8;
   localparam int PERR_POS  = 12;
   localparam int FERR_POS  = 13;
   localparam int OVR_POS   = 14;
   localparam int VALID_POS = 15;

   typedef struct packed {
      logic              ovr;
      logic              ferr;
      logic              perr;
      logic [LINE_W-1:0] line;
      logic [CHAR_W-1:0] data;
   } silo_entry_t;

   function automatic logic [WORD_W-1:0] pack_word(input logic valid, input silo_entry_t e);
      logic [WORD_W-1:0] w;
      w = '0;
      if (valid) begin
         w[CHAR_W-1:0]             = e.data;
         w[LINE_LSB +: LINE_W]     = e.line;
         w[PERR_POS]               = e.perr;
         w[FERR_POS]               = e.ferr;
         w[OVR_POS]                = e.ovr;
         w[VALID_POS]              = 1'b1;
      end
      return w;
   endfunction
endpackage

// File: rtl/silo_arbiter.sv
module silo_arbiter #(
   parameter int NUM_REQ = 8,
   parameter int IDX_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic [NUM_REQ-1:0] req,
   output logic [NUM_REQ-1:0] grant,
   output logic               any_grant,
   output logic [IDX_W-1:0]   grant_idx
);
   if (NUM_REQ < 1 || NUM_REQ > (1 << IDX_W)) begin : g_bad_width
      $error("silo_arbiter: NUM_REQ does not fit the index width");
   end

   logic [NUM_REQ-1:0] lower_busy;

   always_comb begin
      lower_busy = '0;
      for (int i = 1; i < NUM_REQ; i++) begin
         lower_busy[i] = lower_busy[i-1] | req[i-1];
      end
   end

   for (genvar i = 0; i < NUM_REQ; i++) begin : g_pri
      assign grant[i] = enable & req[i] & ~lower_busy[i];
   end

   assign any_grant = |grant;

   always_comb begin
      grant_idx = '0;
      for (int i = NUM_REQ - 1; i >= 0; i--) begin
         if (grant[i]) grant_idx = IDX_W'(i);
      end
   end

   assert_onehot_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   assert_line0_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && req[0]) |-> (grant == NUM_REQ'(1)));
   assert_no_grant_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (grant == '0));
endmodule

// File: rtl/silo_store.sv
module silo_store
   import silo_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  silo_entry_t      push_data,
   input  logic             pop,
   output silo_entry_t      head,
   output logic [CNT_W-1:0] count,
   output logic             empty,
   output logic             full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("silo_store: DEPTH must be a power of two of at least 2");
   end

   silo_entry_t      mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + PTR_W'(1);
         if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
         case ({push, pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wr_ptr] <= push_data;
   end

   assign head  = mem[rd_ptr];
   assign empty = (count == '0);
   assign full  = (count == CNT_W'(DEPTH));

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push) |-> pop);
   assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);
   assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && push && !pop) |=> (count == $past(count) + CNT_W'(1)));
endmodule

// File: rtl/silo_irq.sv
module silo_irq #(
   parameter int DEPTH       = 64,
   parameter int ALARM_LEVEL = 16,
   parameter bit REG_OUT     = 1'b0,
   parameter int CNT_W       = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic             int_en,
   input  logic             alarm_en,
   output logic             irq
);
   if (ALARM_LEVEL < 1 || ALARM_LEVEL > DEPTH) begin : g_bad_level
      $error("silo_irq: ALARM_LEVEL must lie in 1..DEPTH");
   end

   logic level_hit, irq_raw;

   assign level_hit = alarm_en ? (count >= CNT_W'(ALARM_LEVEL)) : (count != '0);
   assign irq_raw   = int_en & level_hit;

   if (REG_OUT) begin : g_registered
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_raw;
      end
   end else begin : g_direct
      assign irq = irq_raw;
      assert_alarm_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (alarm_en && count < CNT_W'(ALARM_LEVEL)) |-> !irq);
      assert_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !int_en |-> !irq);
   end
endmodule

// File: rtl/mux_rx_silo.sv
module mux_rx_silo
   import silo_pkg::*;
#(
   parameter int NUM_LINES   = 8,
   parameter int DEPTH       = 64,
   parameter int ALARM_LEVEL = 16,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        scan_en,
   input  logic                        rx_int_en,
   input  logic                        alarm_en,
   input  logic [NUM_LINES-1:0]        line_push,
   input  logic [NUM_LINES*CHAR_W-1:0] line_char,
   input  logic [NUM_LINES-1:0]        line_ferr,
   input  logic [NUM_LINES-1:0]        line_perr,
   output logic [NUM_LINES-1:0]        line_accept,
   input  logic                        rd_pop,
   output logic [WORD_W-1:0]           rd_word,
   output logic                        rx_irq
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic              any_grant;
   logic [LINE_W-1:0] grant_idx;
   logic              do_push, do_pop, dropped, lost_q;
   logic              s_empty, s_full;
   logic [CNT_W-1:0]  s_count;
   silo_entry_t       new_entry, head_entry;

   silo_arbiter #(.NUM_REQ(NUM_LINES), .IDX_W(LINE_W)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (scan_en),
      .req       (line_push),
      .grant     (line_accept),
      .any_grant (any_grant),
      .grant_idx (grant_idx)
   );

   assign do_pop  = rd_pop & ~s_empty & scan_en;
   assign do_push = any_grant & (~s_full | do_pop);
   assign dropped = any_grant & ~do_push;

   always_comb begin
      new_entry.data = line_char[grant_idx*CHAR_W +: CHAR_W];
      new_entry.line = grant_idx;
      new_entry.ferr = line_ferr[grant_idx];
      new_entry.perr = line_perr[grant_idx];
      new_entry.ovr  = lost_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lost_q <= 1'b0;
      else if (!scan_en) lost_q <= 1'b0;
      else if (dropped)  lost_q <= 1'b1;
      else if (do_push)  lost_q <= 1'b0;
   end

   silo_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (~scan_en),
      .push      (do_push),
      .push_data (new_entry),
      .pop       (do_pop),
      .head      (head_entry),
      .count     (s_count),
      .empty     (s_empty),
      .full      (s_full)
   );

   silo_irq #(.DEPTH(DEPTH), .ALARM_LEVEL(ALARM_LEVEL), .REG_OUT(IRQ_REG), .CNT_W(CNT_W)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .count    (s_count),
      .int_en   (rx_int_en),
      .alarm_en (alarm_en),
      .irq      (rx_irq)
   );

   assign rd_word = pack_word(~s_empty, head_entry);

   assert_overrun_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_en && do_push && lost_q) |=> !lost_q);
   assert_drop_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_en && dropped) |=> lost_q);
   assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_en |=> (rd_word == '0));
endmodule

// File: tb/sim_mux_rx_silo.sv
`timescale 1ns/1ps
module sim_mux_rx_silo;
   localparam int NL = 8;
   localparam int DP = 64;
   localparam int AL = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          scan_en = 1'b0, rx_int_en = 1'b0, alarm_en = 1'b0;
   logic [NL-1:0] line_push = '0, line_ferr = '0, line_perr = '0;
   logic [NL*8-1:0] line_char = '0;
   logic [NL-1:0] line_accept;
   logic          rd_pop = 1'b0;
   logic [15:0]   rd_word;
   logic          rx_irq;

   int errors = 0;
   int checks = 0;
   logic [15:0] mq[$];
   logic        m_lost = 1'b0;

   always #10 clk = ~clk;

   mux_rx_silo #(.NUM_LINES(NL), .DEPTH(DP), .ALARM_LEVEL(AL)) u0 (
      .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .rx_int_en(rx_int_en),
      .alarm_en(alarm_en), .line_push(line_push), .line_char(line_char),
      .line_ferr(line_ferr), .line_perr(line_perr), .line_accept(line_accept),
      .rd_pop(rd_pop), .rd_word(rd_word), .rx_irq(rx_irq)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int lowest(input logic [NL-1:0] v);
      for (int i = 0; i < NL; i++) if (v[i]) return i;
      return -1;
   endfunction

   // one clock: drive after falling edge, check before rising edge, then advance model
   task automatic cycle(input logic [NL-1:0] v, input logic r, output int g);
      logic [NL-1:0] exp_acc;
      logic [15:0]   exp_word;
      logic          exp_irq;
      int            sz;
      @(negedge clk);
      line_push = v;
      rd_pop    = r;
      #2;
      g       = scan_en ? lowest(v) : -1;
      exp_acc = (g >= 0) ? NL'(1 << g) : '0;
      chk(scan_en ? "R7" : "R9", "accept", 32'(line_accept), 32'(exp_acc));
      sz       = mq.size();
      exp_word = (sz > 0) ? mq[0] : 16'h0000;
      chk((sz == 0) ? "R3" : "R1", "read word", 32'(rd_word), 32'(exp_word));
      exp_irq = rx_int_en && (alarm_en ? (sz >= AL) : (sz > 0));
      chk(!rx_int_en ? "R6" : (alarm_en ? "R5" : "R4"), "irq", 32'(rx_irq), 32'(exp_irq));
      if (!scan_en) begin
         mq.delete();
         m_lost = 1'b0;
      end else begin
         logic popped;
         popped = r && (sz > 0);
         if (popped) void'(mq.pop_front());
         if (g >= 0) begin
            if (sz < DP || popped) begin
               mq.push_back({1'b1, m_lost, line_ferr[g], line_perr[g], 1'b0, 3'(g), line_char[g*8 +: 8]});
               m_lost = 1'b0;
            end else begin
               m_lost = 1'b1;
            end
         end
      end
      @(posedge clk);
      #2;
   endtask

   task automatic push_one(input int ln, input logic [7:0] c, input logic fe, input logic pe);
      int g;
      line_char[ln*8 +: 8] = c;
      line_ferr[ln] = fe;
      line_perr[ln] = pe;
      cycle(NL'(1 << ln), 1'b0, g);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      int g;
      logic [NL-1:0] pend;
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      chk("R3", "reset word", 32'(rd_word), 32'h0);
      chk("R6", "reset irq", 32'(rx_irq), 32'h0);
      chk("R9", "reset accept", 32'(line_accept), 32'h0);

      // alarm threshold R5
      scan_en = 1'b1; rx_int_en = 1'b1; alarm_en = 1'b1;
      for (int i = 0; i < AL - 1; i++) push_one(i % NL, 8'(i + 1), 1'b0, 1'b0);
      chk("R5", "irq at 15 entries", 32'(rx_irq), 32'h0);
      push_one(4, 8'h40, 1'b0, 1'b0);
      chk("R5", "irq at 16 entries", 32'(rx_irq), 32'h1);

      // all lines at once, held until served R7
      for (int i = 0; i < NL; i++) line_char[i*8 +: 8] = 8'(8'hA0 + i);
      line_ferr = '0; line_perr = '0;
      pend = '1;
      while (pend != '0) begin
         cycle(pend, 1'b0, g);
         if (g >= 0) pend[g] = 1'b0;
      end

      // fill to full, then overflow R8
      while (mq.size() < DP) push_one(1, 8'(mq.size()), 1'b0, 1'b0);
      for (int i = 0; i < 3; i++) push_one(2, 8'hEE, 1'b1, 1'b1);
      line_char[3*8 +: 8] = 8'h77; line_ferr[3] = 1'b0; line_perr[3] = 1'b0;
      cycle(NL'(1 << 3), 1'b1, g);
      for (int i = 0; i < DP - 1; i++) cycle('0, 1'b1, g);
      chk("R8", "overrun-tagged entry", 32'(rd_word), 32'h0000C377);
      cycle('0, 1'b1, g);
      chk("R3", "empty after drain", 32'(rd_word), 32'h0);
      cycle('0, 1'b1, g);
      chk("R3", "read on empty", 32'(rd_word), 32'h0);

      // break and parity R2
      push_one(5, 8'h00, 1'b1, 1'b0);
      chk("R2", "break word", 32'(rd_word), 32'h0000A500);
      push_one(6, 8'h5A, 1'b0, 1'b1);
      cycle('0, 1'b1, g);
      chk("R2", "parity word", 32'(rd_word), 32'h0000965A);

      // immediate mode and masking R4 R6
      alarm_en = 1'b0;
      cycle('0, 1'b0, g);
      chk("R4", "immediate irq", 32'(rx_irq), 32'h1);
      rx_int_en = 1'b0;
      cycle('0, 1'b0, g);
      chk("R6", "masked irq", 32'(rx_irq), 32'h0);
      rx_int_en = 1'b1;

      // flush R9
      push_one(0, 8'h11, 1'b0, 1'b0);
      push_one(7, 8'h22, 1'b0, 1'b0);
      scan_en = 1'b0;
      cycle('1, 1'b0, g);
      chk("R9", "word after flush", 32'(rd_word), 32'h0);
      chk("R9", "irq after flush", 32'(rx_irq), 32'h0);
      scan_en = 1'b1;

      // constrained random
      for (int n = 0; n < 3000; n++) begin
         logic [NL-1:0] v;
         line_char = {$urandom, $urandom};
         line_ferr = NL'($urandom) & NL'($urandom);
         line_perr = NL'($urandom) & NL'($urandom);
         v = (($urandom % 3) == 0) ? '0 : (NL'($urandom) & NL'($urandom));
         if ((n % 500) == 250) alarm_en = ~alarm_en;
         rx_int_en = ((n % 700) < 600);
         scan_en   = ((n % 997) != 996);
         cycle(v, (($urandom % 5) < ((n % 1000) < 500 ? 1 : 4)), g);
      end
      scan_en = 1'b1;
      cycle('0, 1'b0, g);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule